// File: doc/BRIEF.md
# Memory-Access Mode Transfer Sequencer

This block moves blocks of words between an external debug channel and system memory while the core is stopped. When the core is halted and the memory-access mode bit is set, each word written into the receive register from outside becomes one memory store. Each read of the transmit register from outside returns the current word and starts a memory load that refills that register. Both kinds of access advance a word address by the word size, so a debugger can stream a buffer with nothing but data-register accesses.

A busy flag, exposed as the instruction-complete indication, is low while the single memory request is in flight. A data access that arrives while the flag is low is rejected as an overrun (receive side) or an underrun (transmit side), and the sticky error flag is set. While that flag is set, every later external access is ignored until it is cleared. Outside the mode the two data registers behave as plain mailboxes between the external side and the core, and no memory traffic is made.

Top module: `mmseq_top`

## Requirements
- R1: After reset the instruction-complete flag is 1. The receive-full, transmit-full, error, overrun and underrun flags are 0, no memory request is raised, and the address is 0.
- R2: With halted and mode both 1, no error, the sequencer idle and receive-full 0, a receive write raises in the next cycle a single store request (mem_we_o=1) at the current address that carries the written word. The instruction-complete flag is 0 while that request is in flight.
- R3: When a store completes (mem_done_i), the address increases by 4, receive-full clears and the instruction-complete flag returns to 1.
- R4: With halted and mode both 1, no error, the sequencer idle and transmit-full 1, a transmit read returns the transmit word with tx_rd_ok_o=1 in the same cycle. It clears transmit-full and raises in the next cycle a load request (mem_we_o=0) at the current address.
- R5: When a load completes, the read data is placed in the transmit register, transmit-full sets, the address increases by 4 and the instruction-complete flag returns to 1.
- R6: In the mode, a receive write while a request is in flight sets the overrun and error flags. The word is discarded: the in-flight store keeps its data and no second store follows.
- R7: A transmit read while a request is in flight in the mode, or while transmit-full is 0, gives tx_rd_ok_o=0, sets the underrun and error flags and starts no load.
- R8: If a request ends with mem_abort_i, the error flag sets, the full flag of that direction is 0, the address is unchanged and the instruction-complete flag returns to 1.
- R9: Only one request is outstanding. Request, direction, address and write data stay stable until done or abort.
- R10: While the error flag is 1, receive writes are ignored and transmit reads change no state. A pulse on err_clr_i clears the error, overrun and underrun flags.
- R11: The address port loads the address only while the sequencer is idle. A load while busy is ignored.
- R12: When halted or mode is 0, a receive write latches the word and sets receive-full (overrun and error if already full). A transmit read clears transmit-full (underrun and error if empty). No memory request is made.
- R13: A core-side read (core_rx_rd_i) clears receive-full. A core-side write (core_tx_wr_i) loads the transmit word and sets transmit-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halted_i | input | 1 | Core is halted |
| memmode_i | input | 1 | Memory-access mode bit |
| rx_wr_i | input | 1 | External receive-register write strobe |
| rx_wdata_i | input | DATA_W | External receive write word |
| tx_rd_i | input | 1 | External transmit-register read strobe |
| tx_rdata_o | output | DATA_W | Transmit word returned to the external side |
| tx_rd_ok_o | output | 1 | Current transmit read is accepted and its data valid |
| core_rx_rd_i | input | 1 | Core consumes the receive word |
| rx_data_o | output | DATA_W | Receive word as seen by the core |
| core_tx_wr_i | input | 1 | Core writes the transmit word |
| core_tx_wdata_i | input | DATA_W | Core transmit word |
| addr_wr_i | input | 1 | Address load strobe |
| addr_wdata_i | input | ADDR_W | Address load value |
| addr_o | output | ADDR_W | Current transfer address |
| err_clr_i | input | 1 | Clears error, overrun and underrun flags |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for store, 0 for load |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Store data |
| mem_rdata_i | input | DATA_W | Load data, valid with mem_done_i |
| mem_done_i | input | 1 | Request completed |
| mem_abort_i | input | 1 | Request aborted |
| ite_o | output | 1 | Instruction-complete (not busy) flag |
| rx_full_o | output | 1 | Receive register full |
| tx_full_o | output | 1 | Transmit register full |
| err_o | output | 1 | Sticky error flag |
| rx_ovr_o | output | 1 | Receive overrun flag |
| tx_und_o | output | 1 | Transmit underrun flag |

## Verification
Several properties hold on every clock. A store or load started in the mode raises exactly one request and keeps it stable until done or abort. Completion advances the address by one word and fills or empties the right register. An abort leaves the address alone. Busy-time data accesses always end in overrun or underrun, and a busy address load changes nothing. Only the bench's scenarios can show the end-to-end effects: a streamed buffer lands in memory at consecutive addresses, a loaded word is what the next external read returns, a discarded overrun word never reaches memory, and the sticky error flag blocks later accesses until cleared.

// File: rtl/mmseq_pkg.sv
package mmseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STORE = 2'd1,
      ST_LOAD  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/mmseq_addr.sv
module mmseq_addr #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4,
   parameter bit ALIGN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int LSB = (STEP > 1) ? $clog2(STEP) : 1;

   generate
      if ((STEP & (STEP - 1)) != 0 || STEP < 1)
         $error("mmseq_addr: STEP must be a power of two");
      if (ADDR_W <= LSB)
         $error("mmseq_addr: ADDR_W too small for STEP");
   endgenerate

   logic [ADDR_W-1:0] ld_fix;

   generate
      if (ALIGN && STEP > 1) begin : g_align
         assign ld_fix = {ld_val[ADDR_W-1:LSB], {LSB{1'b0}}};
      end else begin : g_raw
         assign ld_fix = ld_val;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   addr_o <= '0;
      else if (ld)  addr_o <= ld_fix;
      else if (inc) addr_o <= addr_o + ADDR_W'(STEP);
   end
endmodule

// File: rtl/mmseq_fsm.sv
module mmseq_fsm
   import mmseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_st,
   input  logic       start_ld,
   input  logic       done,
   input  logic       abort,
   output seq_state_t state_o,
   output logic       fin_ok,
   output logic       fin_abort
);
   seq_state_t nxt;
   logic       busy;

   assign busy      = (state_o != ST_IDLE);
   assign fin_ok    = busy && done;
   assign fin_abort = busy && abort && !done;

   always_comb begin
      nxt = state_o;
      unique case (state_o)
         ST_IDLE: begin
            if (start_st)      nxt = ST_STORE;
            else if (start_ld) nxt = ST_LOAD;
         end
         ST_STORE, ST_LOAD: begin
            if (done || abort) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= nxt;
   end

   // R9: a request in flight keeps its kind until it ends
   a_r9_hold_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !abort) |=> (state_o == $past(state_o)));
   // R9: no new request is launched on top of one in flight
   a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(start_st || start_ld));
endmodule

// File: rtl/mmseq_top.sv
module mmseq_top
   import mmseq_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter bit ALIGN_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halted_i,
   input  logic              memmode_i,
   input  logic              rx_wr_i,
   input  logic [DATA_W-1:0] rx_wdata_i,
   input  logic              tx_rd_i,
   output logic [DATA_W-1:0] tx_rdata_o,
   output logic              tx_rd_ok_o,
   input  logic              core_rx_rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   input  logic              core_tx_wr_i,
   input  logic [DATA_W-1:0] core_tx_wdata_i,
   input  logic              addr_wr_i,
   input  logic [ADDR_W-1:0] addr_wdata_i,
   output logic [ADDR_W-1:0] addr_o,
   input  logic              err_clr_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_done_i,
   input  logic              mem_abort_i,
   output logic              ite_o,
   output logic              rx_full_o,
   output logic              tx_full_o,
   output logic              err_o,
   output logic              rx_ovr_o,
   output logic              tx_und_o
);
   localparam int STEP = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8)
         $error("mmseq_top: DATA_W must be a whole number of bytes");
   endgenerate

   seq_state_t        state;
   logic              fin_ok, fin_abort;
   logic              active, idle;
   logic              rx_busy_cond, tx_busy_cond;
   logic              rx_take, rx_over, tx_take, tx_under;
   logic              start_st, start_ld;
   logic [DATA_W-1:0] rx_word, tx_word;
   logic              rx_full, tx_full, err, rx_ovr, tx_und;

   assign active       = halted_i && memmode_i;
   assign idle         = (state == ST_IDLE);
   assign rx_busy_cond = rx_full || (active && !idle);
   assign tx_busy_cond = !tx_full || (active && !idle);
   assign rx_take      = rx_wr_i && !err && !rx_busy_cond;
   assign rx_over      = rx_wr_i && !err && rx_busy_cond;
   assign tx_take      = tx_rd_i && !err && !tx_busy_cond;
   assign tx_under     = tx_rd_i && !err && tx_busy_cond;
   assign start_st     = rx_take && active;
   assign start_ld     = tx_take && active && !start_st;

   mmseq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_st  (start_st),
      .start_ld  (start_ld),
      .done      (mem_done_i),
      .abort     (mem_abort_i),
      .state_o   (state),
      .fin_ok    (fin_ok),
      .fin_abort (fin_abort)
   );

   mmseq_addr #(
      .ADDR_W (ADDR_W),
      .STEP   (STEP),
      .ALIGN  (ALIGN_ADDR)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (addr_wr_i && idle),
      .ld_val (addr_wdata_i),
      .inc    (fin_ok),
      .addr_o (addr_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_word <= '0;
         tx_word <= '0;
         rx_full <= 1'b0;
         tx_full <= 1'b0;
         err     <= 1'b0;
         rx_ovr  <= 1'b0;
         tx_und  <= 1'b0;
      end else begin
         if (core_rx_rd_i) rx_full <= 1'b0;
         if (rx_take) begin
            rx_word <= rx_wdata_i;
            rx_full <= 1'b1;
         end
         if (state == ST_STORE && (fin_ok || fin_abort)) rx_full <= 1'b0;

         if (tx_take) tx_full <= 1'b0;
         if (core_tx_wr_i) begin
            tx_word <= core_tx_wdata_i;
            tx_full <= 1'b1;
         end
         if (state == ST_LOAD && fin_ok) begin
            tx_word <= mem_rdata_i;
            tx_full <= 1'b1;
         end
         if (state == ST_LOAD && fin_abort) tx_full <= 1'b0;

         if (err_clr_i) begin
            err    <= 1'b0;
            rx_ovr <= 1'b0;
            tx_und <= 1'b0;
         end
         if (rx_over)   begin rx_ovr <= 1'b1; err <= 1'b1; end
         if (tx_under)  begin tx_und <= 1'b1; err <= 1'b1; end
         if (fin_abort) err <= 1'b1;
      end
   end

   assign tx_rdata_o  = tx_word;
   assign tx_rd_ok_o  = tx_take;
   assign rx_data_o   = rx_word;
   assign mem_req_o   = !idle;
   assign mem_we_o    = (state == ST_STORE);
   assign mem_addr_o  = addr_o;
   assign mem_wdata_o = rx_word;
   assign ite_o       = idle;
   assign rx_full_o   = rx_full;
   assign tx_full_o   = tx_full;
   assign err_o       = err;
   assign rx_ovr_o    = rx_ovr;
   assign tx_und_o    = tx_und;

   // R2: accepted receive write in the mode becomes one store of that word
   a_r2_store_start: assert property (@(posedge clk) disable iff (!rst_n)
      (active && idle && rx_wr_i && !err && !rx_full) |=>
         (mem_req_o && mem_we_o && !ite_o && mem_wdata_o == $past(rx_wdata_i)));
   // R3: completed store advances the address and empties the receive side
   a_r3_store_done: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o && mem_done_i) |=>
         (addr_o == $past(addr_o) + ADDR_W'(STEP) && !rx_full_o && ite_o));
   // R5: completed load refills the transmit register
   a_r5_load_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_we_o && mem_done_i) |=>
         (tx_full_o && tx_rdata_o == $past(mem_rdata_i) &&
          addr_o == $past(addr_o) + ADDR_W'(STEP) && ite_o));
   // R6: receive write while busy in the mode is an overrun
   a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mem_req_o && rx_wr_i && !err_o) |=> (err_o && rx_ovr_o));
   // R7: transmit read while busy or empty is an underrun
   a_r7_underrun: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rd_i && !err_o && (!tx_full_o || (active && mem_req_o))) |->
         (!tx_rd_ok_o ##1 (err_o && tx_und_o)));
   // R8: abort sets error, keeps the address, returns to idle
   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_abort_i && !mem_done_i) |=>
         (err_o && ite_o && addr_o == $past(addr_o) &&
          ($past(mem_we_o) ? !rx_full_o : !tx_full_o)));
   // R9: request attributes stay stable while in flight
   a_r9_stable_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_done_i && !mem_abort_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) &&
          (!mem_we_o || $stable(mem_wdata_o))));
   // R11: address load while busy is ignored
   a_r11_addr_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && addr_wr_i && !mem_done_i) |=> (addr_o == $past(addr_o)));
   // R12: outside the mode no request is started
   a_r12_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && ite_o) |=> !mem_req_o);
endmodule

// File: tb/sim_mmseq_top.sv
module sim_mmseq_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 2;
   localparam int NVEC       = 5;
   localparam logic        VOP  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
   localparam logic [31:0] VDAT [NVEC] = '{32'hDEAD0001, 32'hBEEF0002,
                                           32'hF00D0003, 32'h0, 32'h0};

   logic        clk, rst_n, halted, memmode;
   logic        rx_wr, tx_rd, core_rx_rd, core_tx_wr, addr_wr, err_clr;
   logic [31:0] rx_wdata, core_tx_wdata, addr_wdata;
   logic [31:0] tx_rdata, rx_data, addr, mem_addr, mem_wdata, mem_rdata;
   logic        tx_rd_ok, mem_req, mem_we, mem_done, mem_abort;
   logic        ite, rx_full, tx_full, err, rx_ovr, tx_und;

   int n_chk = 0;
   int n_fail = 0;
   logic        abort_en;
   logic [31:0] abort_addr;
   logic [31:0] mem_rec [16];
   int          cnt;

   mmseq_top u0 (
      .clk(clk), .rst_n(rst_n), .halted_i(halted), .memmode_i(memmode),
      .rx_wr_i(rx_wr), .rx_wdata_i(rx_wdata), .tx_rd_i(tx_rd),
      .tx_rdata_o(tx_rdata), .tx_rd_ok_o(tx_rd_ok),
      .core_rx_rd_i(core_rx_rd), .rx_data_o(rx_data),
      .core_tx_wr_i(core_tx_wr), .core_tx_wdata_i(core_tx_wdata),
      .addr_wr_i(addr_wr), .addr_wdata_i(addr_wdata), .addr_o(addr),
      .err_clr_i(err_clr), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .mem_done_i(mem_done), .mem_abort_i(mem_abort), .ite_o(ite),
      .rx_full_o(rx_full), .tx_full_o(tx_full), .err_o(err),
      .rx_ovr_o(rx_ovr), .tx_und_o(tx_und)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] fmem(input logic [31:0] a);
      return 32'hC0DE0000 | {16'h0, a[15:0]};
   endfunction

   always @(posedge clk) begin
      mem_done  <= 1'b0;
      mem_abort <= 1'b0;
      if (!rst_n) begin
         cnt <= 0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_done && !mem_abort) begin
         if (cnt == LAT) begin
            cnt <= 0;
            if (abort_en && mem_addr == abort_addr) mem_abort <= 1'b1;
            else begin
               mem_done <= 1'b1;
               if (mem_we) mem_rec[mem_addr[5:2]] <= mem_wdata;
               else        mem_rdata <= fmem(mem_addr);
            end
         end else cnt <= cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rx_write(input logic [31:0] d);
      rx_wr = 1'b1; rx_wdata = d;
      @(negedge clk);
      rx_wr = 1'b0;
   endtask

   task automatic pulse_clr();
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 50; k++) begin
         if (ite) break;
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] a0, exp_tx;
      rst_n = 0; halted = 0; memmode = 0; rx_wr = 0; tx_rd = 0;
      core_rx_rd = 0; core_tx_wr = 0; addr_wr = 0; err_clr = 0;
      rx_wdata = 0; core_tx_wdata = 0; addr_wdata = 0;
      abort_en = 0; abort_addr = 0;
      for (int k = 0; k < 16; k++) mem_rec[k] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ite", {31'b0, ite}, 32'd1);
      chk("R1 flags", {26'b0, rx_full, tx_full, err, rx_ovr, tx_und, mem_req}, 32'd0);
      chk("R1 addr", addr, 32'd0);
      rst_n = 1;
      @(negedge clk);

      halted = 1; memmode = 1;
      addr_wr = 1; addr_wdata = 32'h100;
      @(negedge clk);
      addr_wr = 0;
      chk("R11 idle load", addr, 32'h100);

      core_tx_wr = 1; core_tx_wdata = 32'h11111111;
      @(negedge clk);
      core_tx_wr = 0;
      chk("R13 core tx write", {31'b0, tx_full}, 32'd1);
      exp_tx = 32'h11111111;

      // table walk: stream stores then loads
      for (int i = 0; i < NVEC; i++) begin
         a0 = addr;
         if (VOP[i] == 1'b0) begin
            rx_write(VDAT[i]);
            chk("R2 store req", {29'b0, mem_req, mem_we, ite}, 32'b110);
            chk("R2 store addr", mem_addr, a0);
            chk("R2 store data", mem_wdata, VDAT[i]);
            wait_idle();
            chk("R3 addr inc", addr, a0 + 32'd4);
            chk("R3 rx empty", {31'b0, rx_full}, 32'd0);
            chk("R2 memory word", mem_rec[a0[5:2]], VDAT[i]);
         end else begin
            tx_rd = 1'b1;
            #1;
            chk("R4 read ok", {31'b0, tx_rd_ok}, 32'd1);
            chk("R4 read data", tx_rdata, exp_tx);
            @(negedge clk);
            tx_rd = 1'b0;
            chk("R4 tx cleared+load", {29'b0, tx_full, mem_req, mem_we}, 32'b010);
            chk("R4 load addr", mem_addr, a0);
            wait_idle();
            chk("R5 tx refilled", {31'b0, tx_full}, 32'd1);
            chk("R5 tx word", tx_rdata, fmem(a0));
            chk("R5 addr inc", addr, a0 + 32'd4);
            exp_tx = fmem(a0);
         end
      end

      // R6 / R9: overrun during a store
      a0 = addr;
      rx_write(32'hAAAA0001);
      rx_write(32'hBBBB0002);
      chk("R6 overrun flags", {30'b0, err, rx_ovr}, 32'b11);
      chk("R9 req held", {31'b0, mem_req}, 32'd1);
      chk("R9 addr held", mem_addr, a0);
      chk("R9 data held", mem_wdata, 32'hAAAA0001);
      wait_idle();
      chk("R6 first word stored", mem_rec[a0[5:2]], 32'hAAAA0001);
      chk("R6 single store", addr, a0 + 32'd4);

      // R10: error flag blocks accesses
      a0 = addr;
      rx_write(32'hCCCC0003);
      chk("R10 rx ignored", {30'b0, mem_req, rx_full}, 32'd0);
      chk("R10 addr kept", addr, a0);
      tx_rd = 1'b1;
      #1;
      chk("R10 tx not ok", {31'b0, tx_rd_ok}, 32'd0);
      @(negedge clk);
      tx_rd = 1'b0;
      chk("R10 tx no side effect", {30'b0, tx_full, mem_req}, 32'b10);
      pulse_clr();
      chk("R10 clear", {29'b0, err, rx_ovr, tx_und}, 32'd0);

      // R7: transmit read while busy
      rx_write(32'hDDDD0004);
      tx_rd = 1'b1;
      #1;
      chk("R7 busy read rejected", {31'b0, tx_rd_ok}, 32'd0);
      @(negedge clk);
      tx_rd = 1'b0;
      chk("R7 underrun flags", {30'b0, err, tx_und}, 32'b11);
      wait_idle();
      chk("R7 tx kept", {31'b0, tx_full}, 32'd1);
      pulse_clr();

      // R11: address load while busy ignored
      a0 = addr;
      rx_write(32'hEEEE0005);
      addr_wr = 1; addr_wdata = 32'h200;
      @(negedge clk);
      addr_wr = 0;
      wait_idle();
      chk("R11 busy load ignored", addr, a0 + 32'd4);

      // R8: abort of a store, then of a load
      a0 = addr;
      abort_en = 1; abort_addr = a0;
      rx_write(32'h77770006);
      wait_idle();
      chk("R8 store abort flags", {29'b0, err, rx_full, ite}, 32'b101);
      chk("R8 store abort addr", addr, a0);
      pulse_clr();
      tx_rd = 1'b1;
      @(negedge clk);
      tx_rd = 1'b0;
      wait_idle();
      chk("R8 load abort flags", {29'b0, err, tx_full, ite}, 32'b101);
      chk("R8 load abort addr", addr, a0);
      pulse_clr();
      abort_en = 0;

      // R7: transmit read with empty register
      tx_rd = 1'b1;
      #1;
      chk("R7 empty read rejected", {31'b0, tx_rd_ok}, 32'd0);
      @(negedge clk);
      tx_rd = 1'b0;
      chk("R7 empty underrun", {29'b0, err, tx_und, mem_req}, 32'b110);
      pulse_clr();

      // R12 / R13: mailbox behaviour outside the mode
      halted = 0;
      rx_write(32'h12345678);
      chk("R12 rx latched", rx_data, 32'h12345678);
      chk("R12 rx full no req", {30'b0, rx_full, mem_req}, 32'b10);
      rx_write(32'h9ABCDEF0);
      chk("R12 outside overrun", {30'b0, err, rx_ovr}, 32'b11);
      chk("R12 word kept", rx_data, 32'h12345678);
      pulse_clr();
      core_rx_rd = 1;
      @(negedge clk);
      core_rx_rd = 0;
      chk("R13 core read clears", {31'b0, rx_full}, 32'd0);
      core_tx_wr = 1; core_tx_wdata = 32'h55;
      @(negedge clk);
      core_tx_wr = 0;
      tx_rd = 1'b1;
      #1;
      chk("R12 outside read ok", {31'b0, tx_rd_ok}, 32'd1);
      chk("R13 core tx data", tx_rdata, 32'h55);
      @(negedge clk);
      tx_rd = 1'b0;
      chk("R12 outside read no load", {30'b0, tx_full, mem_req}, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule